// File: doc/BRIEF.md
# Indirect Switch Register Reader over MDIO

This block reads one 16-bit register from a switch chip that cannot be reached with a plain MDIO access. The host raises a one-cycle read request with a 16-bit switch address. The block then runs a fixed series of eight clause-22 transactions on a simple transaction port. A separate MDIO master on that port does the serial framing.

Each command write is preceded by a 0xFFFF write to register 0x1D. The commands are, in order:
- a mode write of 0x000E to register 0x1F;
- the target address written to register 0x17;
- a trigger value of 1 written to register 0x15.

One more 0xFFFF prefix is written to 0x1D before the final read of register 0x19. The value returned by that read is latched to the result output, and a one-cycle done pulse marks completion.

Every transaction waits for its acknowledge before the next one is issued. While a sequence runs, the block reports busy and ignores further requests.

Top module: `swreg_indirect_reader`

## Requirements
- R1: Every transaction presented on the port (`mt_req` high) carries PHY address 0.
- R2: Steps 0, 2, 4 and 6 of a sequence are writes (`mt_write`=1) of 0xFFFF to register 0x1D.
- R3: Step 1 is a write of 0x000E to register 0x1F.
- R4: Step 3 is a write of the captured 16-bit switch address to register 0x17.
- R5: Step 5 is a write of 0x0001 to register 0x15.
- R6: Step 7 is a read (`mt_write`=0) of register 0x19. The `mt_rdata` value acknowledged with it appears on `rd_data`.
- R7: Exactly eight steps run, in order. A step advances only on the cycle `mt_ack` is sampled high, and the port fields stay stable while `mt_req` waits.
- R8: A request is accepted only while `busy` is low. Requests raised while busy are ignored: they neither restart nor queue a sequence.
- R9: On completion `rd_done` is high for exactly one cycle with `busy` low. `rd_data` holds its value until the next completion.
- R10: The address is captured on the accepting clock edge. Later changes of `rd_addr` do not affect a running sequence.
- R11: A synchronous active-high `rst` aborts any sequence. One edge later, `busy`, `mt_req` and `rd_done` are low, and `rd_data` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Host read request, sampled when idle |
| rd_addr | input | 16 | Switch register address |
| busy | output | 1 | Sequence in progress |
| rd_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Latched read result |
| mt_req | output | 1 | Transaction request to MDIO master |
| mt_write | output | 1 | 1 = write, 0 = read |
| mt_phy | output | 5 | PHY address |
| mt_reg | output | 5 | Register number |
| mt_wdata | output | 16 | Write data |
| mt_ack | input | 1 | Transaction complete (one cycle) |
| mt_rdata | input | 16 | Read data, valid with `mt_ack` |

## Verification
Two events can fall on the same edge. The first is completion together with acceptance of the next request. The bench keeps `rd_req` high with a new address through the done cycle. It then checks that `rd_done` pulses once with the old result and that the following sequence writes the new address at step 3. The second is an acknowledge arriving in the same cycle as reset. The bench resets mid-sequence while the master model may be acknowledging. It then checks that the port goes quiet and that a fresh read runs all eight steps from step 0.

// File: rtl/swrd_pkg.sv
package swrd_pkg;
  localparam int DATA_W    = 16;
  localparam int REG_W     = 5;
  localparam int PHY_W     = 5;
  localparam int NUM_STEPS = 8;
  localparam int IDX_W     = $clog2(NUM_STEPS);

  localparam logic [REG_W-1:0]  REG_PREFIX  = 5'h1D;
  localparam logic [REG_W-1:0]  REG_MODE    = 5'h1F;
  localparam logic [REG_W-1:0]  REG_ADDR    = 5'h17;
  localparam logic [REG_W-1:0]  REG_TRIG    = 5'h15;
  localparam logic [REG_W-1:0]  REG_RESULT  = 5'h19;
  localparam logic [DATA_W-1:0] VAL_PREFIX  = 16'hFFFF;
  localparam logic [DATA_W-1:0] VAL_MODE    = 16'h000E;
  localparam logic [DATA_W-1:0] VAL_TRIG    = 16'h0001;

  typedef struct packed {
    logic              is_wr;
    logic [REG_W-1:0]  regnum;
    logic [DATA_W-1:0] wdata;
  } step_t;

  // Odd steps carry a command or the final read; even steps are prefixes.
  function automatic step_t step_of(input logic [IDX_W-1:0] idx,
                                    input logic [DATA_W-1:0] addr);
    step_t s;
    s.is_wr  = 1'b1;
    s.regnum = REG_PREFIX;
    s.wdata  = VAL_PREFIX;
    if (idx[0]) begin
      case (idx[IDX_W-1:1])
        2'd0: begin s.regnum = REG_MODE;   s.wdata = VAL_MODE; end
        2'd1: begin s.regnum = REG_ADDR;   s.wdata = addr;     end
        2'd2: begin s.regnum = REG_TRIG;   s.wdata = VAL_TRIG; end
        default: begin
          s.is_wr  = 1'b0;
          s.regnum = REG_RESULT;
          s.wdata  = '0;
        end
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/swrd_seq.sv
module swrd_seq
  import swrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ack,
  output logic             active,
  output logic [IDX_W-1:0] step,
  output logic             accept,
  output logic             finish
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_STEPS - 1);

  logic at_last;
  assign at_last = (step == LAST);
  assign accept  = !active && start;
  assign finish  = active && ack && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      step   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      step   <= '0;
    end else if (active && ack) begin
      if (at_last) active <= 1'b0;
      else         step   <= step + 1'b1;
    end
  end

  // R7: a waiting step neither moves nor ends
  p_step_hold_r7: assert property (@(posedge clk) disable iff (rst)
    active && !ack |=> active && $stable(step));
  // R7: an acknowledged step advances by exactly one
  p_step_adv_r7: assert property (@(posedge clk) disable iff (rst)
    active && ack && !at_last |=> active && step == $past(step) + 1'b1);
  // R8: a running sequence is not restarted by a new request
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    active && start && !ack |=> step == $past(step));
endmodule

// File: rtl/swrd_xact.sv
module swrd_xact
  import swrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] addr_in,
  input  logic [IDX_W-1:0]  step,
  output logic              is_wr,
  output logic [REG_W-1:0]  regnum,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] addr_q;
  step_t             cur;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (accept) addr_q <= addr_in;
  end

  always_comb begin
    cur    = step_of(step, addr_q);
    is_wr  = cur.is_wr;
    regnum = cur.regnum;
    wdata  = cur.wdata;
  end

  // R10: the captured address only changes on an accepting edge
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(addr_q));
endmodule

// File: rtl/swrd_result.sv
module swrd_result
  import swrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              finish,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [DATA_W-1:0] data_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) data_q <= rdata_in;
    end
  end

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R9: result holds between completions
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(data_q));
endmodule

// File: rtl/swreg_indirect_reader.sv
module swreg_indirect_reader
  import swrd_pkg::*;
#(
  parameter logic [PHY_W-1:0] PHY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_addr,
  output logic              busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mt_req,
  output logic              mt_write,
  output logic [PHY_W-1:0]  mt_phy,
  output logic [REG_W-1:0]  mt_reg,
  output logic [DATA_W-1:0] mt_wdata,
  input  logic              mt_ack,
  input  logic [DATA_W-1:0] mt_rdata
);
  logic             seq_active;
  logic [IDX_W-1:0] seq_step;
  logic             ev_accept;
  logic             ev_finish;

  swrd_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (rd_req),
    .ack    (mt_ack),
    .active (seq_active),
    .step   (seq_step),
    .accept (ev_accept),
    .finish (ev_finish)
  );

  swrd_xact u_xact (
    .clk     (clk),
    .rst     (rst),
    .accept  (ev_accept),
    .addr_in (rd_addr),
    .step    (seq_step),
    .is_wr   (mt_write),
    .regnum  (mt_reg),
    .wdata   (mt_wdata)
  );

  swrd_result u_res (
    .clk      (clk),
    .rst      (rst),
    .finish   (ev_finish),
    .rdata_in (mt_rdata),
    .data_q   (rd_data),
    .done_q   (rd_done)
  );

  assign busy   = seq_active;
  assign mt_req = seq_active;
  assign mt_phy = PHY_ADDR;

  // R1: every presented transaction uses PHY 0 (default build)
  p_phy_zero_r1: assert property (@(posedge clk) disable iff (rst)
    mt_req |-> mt_phy == PHY_ADDR);
  // R7: fields stay put while waiting for an acknowledge
  p_fields_stable_r7: assert property (@(posedge clk) disable iff (rst)
    mt_req && !mt_ack |=> mt_req && $stable(mt_write) && $stable(mt_reg) && $stable(mt_wdata));
  // R9: done never overlaps busy
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !busy);
  // R6: the final read is the completing transaction
  p_read_last_r6: assert property (@(posedge clk) disable iff (rst)
    mt_req && mt_ack && !mt_write |=> rd_done && rd_data == $past(mt_rdata));
  // R11: reset quiets the block one edge later
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> !busy && !mt_req && !rd_done);
endmodule

// File: tb/tb_swreg_indirect_reader.sv
module tb_swreg_indirect_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        busy, rd_done, mt_req, mt_write;
  logic [15:0] rd_data, mt_wdata;
  logic [4:0]  mt_phy, mt_reg;
  logic        mt_ack = 1'b0;
  logic [15:0] mt_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  int seed_dummy;

  logic [15:0] cur_addr = '0;
  int          k = 0;
  bit          pending = 0;
  int          wait_left = 0;
  logic        l_wr;
  logic [4:0]  l_reg;
  logic [15:0] l_wd;

  swreg_indirect_reader dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .busy(busy), .rd_done(rd_done), .rd_data(rd_data),
    .mt_req(mt_req), .mt_write(mt_write), .mt_phy(mt_phy),
    .mt_reg(mt_reg), .mt_wdata(mt_wdata), .mt_ack(mt_ack), .mt_rdata(mt_rdata)
  );

  always #2 clk = ~clk;

  // Expected step content, written as its own table from the requirements
  function automatic logic [21:0] exp_step(input int s, input logic [15:0] a);
    // {is_write, reg[4:0], data[15:0]}
    if (s % 2 == 0) return {1'b1, 5'h1D, 16'hFFFF};   // R2
    if (s == 1)     return {1'b1, 5'h1F, 16'h000E};   // R3
    if (s == 3)     return {1'b1, 5'h17, a};          // R4
    if (s == 5)     return {1'b1, 5'h15, 16'h0001};   // R5
    return {1'b0, 5'h19, 16'h0000};                   // R6
  endfunction

  function automatic logic [15:0] resp(input logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'h5AC3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
      finish_run();
    end
  end

  // MDIO master model: ack after 0..3 cycles, checks each step
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        mt_ack = 0; pending = 0; k = 0;
      end else if (mt_ack) begin
        mt_ack = 0;
      end else if (mt_req) begin
        if (!pending) begin
          logic [21:0] e;
          e = exp_step(k, cur_addr);
          chk(mt_phy == 5'd0, "R1", {27'd0, mt_phy}, 32'd0);
          chk({mt_write, mt_reg, mt_wdata} == e, (k == 3) ? "R4/R10" : (k == 7 ? "R6" : (k % 2 == 0 ? "R2" : (k == 1 ? "R3" : "R5"))),
              {10'd0, mt_write, mt_reg, mt_wdata}, {10'd0, e});
          l_wr = mt_write; l_reg = mt_reg; l_wd = mt_wdata;
          pending = 1;
          wait_left = $urandom % 4;
        end else begin
          chk(mt_write == l_wr && mt_reg == l_reg && mt_wdata == l_wd, "R7",
              {10'd0, mt_write, mt_reg, mt_wdata}, {10'd0, l_wr, l_reg, l_wd});
        end
        if (wait_left == 0) begin
          mt_ack = 1;
          mt_rdata = (k == 7) ? resp(cur_addr) : 16'($urandom);
          pending = 0;
          k = (k == 7) ? 0 : k + 1;
        end else begin
          wait_left--;
        end
      end
    end
  end

  // Wait for done, poking stray requests while busy
  task automatic wait_done(input logic [15:0] a, input bit pokes);
    int t = 0;
    while (!rd_done && t < 300) begin
      @(negedge clk);
      rd_req = 0;
      if (!rd_done && busy && pokes && ($urandom % 3 == 0)) begin
        rd_req = 1; rd_addr = 16'($urandom);   // R8: must be ignored
      end
      t++;
    end
    chk(rd_done, "R9", {31'd0, rd_done}, 32'd1);
    chk(!busy, "R9", {31'd0, busy}, 32'd0);
    chk(rd_data == resp(a), "R6", {16'd0, rd_data}, {16'd0, resp(a)});
  endtask

  task automatic do_read(input logic [15:0] a, input bit pokes);
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_addr = a; rd_addr = a; rd_req = 1;
    @(negedge clk);
    rd_req = 0; rd_addr = ~a;                     // R10: changed after capture
    chk(busy, "R8", {31'd0, busy}, 32'd1);
    wait_done(a, pokes);
    @(negedge clk);
    chk(!rd_done, "R9", {31'd0, rd_done}, 32'd0);
    chk(rd_data == resp(a), "R9", {16'd0, rd_data}, {16'd0, resp(a)});
    repeat (3) @(negedge clk);
    chk(!mt_req && !busy, "R8", {30'd0, mt_req, busy}, 32'd0);
  endtask

  initial begin
    seed_dummy = $urandom(32'h1F2E3D4C);
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_done && !mt_req, "R11", {29'd0, busy, rd_done, mt_req}, 32'd0);
    chk(rd_data == 16'd0, "R11", {16'd0, rd_data}, 32'd0);
    rst = 0;

    // Directed corners
    do_read(16'h0000, 0);
    do_read(16'hFFFF, 0);
    do_read(16'h1234, 1);

    // Back-to-back: request held through the done cycle
    @(negedge clk);
    cur_addr = 16'hA001; rd_addr = 16'hA001; rd_req = 1;
    @(negedge clk);
    chk(busy, "R8", {31'd0, busy}, 32'd1);
    rd_addr = 16'hB002;                            // R10 and next request
    begin
      int t = 0;
      while (!rd_done && t < 300) begin @(negedge clk); t++; end
    end
    chk(rd_done && rd_data == resp(16'hA001), "R9", {15'd0, rd_done, rd_data}, {15'd0, 1'b1, resp(16'hA001)});
    cur_addr = 16'hB002;                           // accepted on the next edge
    @(negedge clk);
    rd_req = 0;
    chk(busy && !rd_done, "R8", {30'd0, busy, rd_done}, 32'd2);
    wait_done(16'hB002, 0);

    // Reset mid-sequence (R11), then a full fresh read
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_addr = 16'h7E57; rd_addr = 16'h7E57; rd_req = 1;
    @(negedge clk); rd_req = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(!busy && !mt_req && !rd_done, "R11", {29'd0, busy, mt_req, rd_done}, 32'd0);
    chk(rd_data == 16'd0, "R11", {16'd0, rd_data}, 32'd0);
    rst = 0;
    do_read(16'h0F0F, 0);

    // Constrained random
    for (int i = 0; i < 40; i++) begin
      do_read(16'($urandom), ($urandom % 2) == 1);
    end

    finish_run();
  end
endmodule